// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Controller

This block gathers up to 32 interrupt lines from peripherals and combines them into one interrupt request for a processor. Each line is first brought into the controller's clock domain. It is then watched for either a level or an edge, and the active sense is chosen per line. A detected event sets a pending bit for that line. The pending bit is reported, and counted towards the request, only while the line is enabled.

Software reaches the controller through a plain 32-bit read/write register port in a 4 KB window, one bit per source in every register. A write completes in the cycle its select is high. A read returns its data one cycle later, marked by a one-cycle valid pulse. The port never stalls, so it has no back-pressure. Pending bits are dropped by writing ones to a clear register. A level source whose input is still active is latched again at once. An edge source keeps its latched event across a disable until it is cleared.

Top module: `intc_top`

## Requirements
- R1: After reset the enable, trigger-mode and trigger-sense registers read 0, the masked status reads 0 and `irq_o` is low.
- R2: A source with mode bit 0 and sense bit 0 latches pending while its input is high. The latch stays set after the input falls, until it is cleared.
- R3: A source with mode bit 0 and sense bit 1 is active-low: it latches pending while its input is low.
- R4: A source with mode bit 1 and sense bit 0 latches pending on a 0-to-1 input transition and holds it after the input returns to 0.
- R5: A source with mode bit 1 and sense bit 1 latches on a 1-to-0 transition only. A 0-to-1 transition sets nothing.
- R6: Writing the clear register (byte offset 0x08) drops the pending bits written as 1 and leaves the bits written as 0 unchanged.
- R7: Masked status (offset 0x14) equals pending AND enable (offset 0x04). A pending source that is disabled does not show in status and does not raise `irq_o`.
- R8: Clearing a level source whose input is still active leaves its pending bit set, with no cycle in which status drops.
- R9: Disabling an edge source keeps its latched edge, and re-enabling it shows the edge in status again.
- R10: `irq_o` is the OR of all status bits, registered. It rises exactly one clock after the enable write that unmasks a pending source.
- R11: Offset 0x00 reads the input states after the two-flop synchroniser. A change driven before clock edge k is seen by a read captured at edge k+2 and not by reads captured at edges k or k+1.
- R12: Offsets 0x04 (enable), 0x0C (trigger mode, 1 = edge) and 0x10 (trigger sense, 1 = low/falling) read back what was written. The clear register at offset 0x08 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt source inputs, asynchronous |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address inside the 4 KB window (word aligned) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read strobe |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A pending bit stuck high shows as a status read that never returns to zero after a clear, and as `irq_o` staying high. A pending bit lost too early shows as a missing status bit after the input has gone idle, visible on the next read. A wrong sense or mode shows as status set on the wrong transition, within three clocks of the input change. A mistimed request path or synchroniser shows as `irq_o`, or the raw read, changing one cycle early or late against the cycle-exact checks.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 12;

  // word index of each register inside the window (byte offset = index * 4)
  typedef enum logic [2:0] {
    REG_RAW  = 3'd0,
    REG_EN   = 3'd1,
    REG_CLR  = 3'd2,
    REG_MODE = 3'd3,
    REG_SNS  = 3'd4,
    REG_STAT = 3'd5
  } reg_idx_e;

  localparam int unsigned REG_LAST = 5;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned N      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prev_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [N-1:0] chain_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= async_i;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign cur_o  = chain_q[STAGES-1];
  assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/intc_detect.sv
module intc_detect #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cur_i,
  input  logic [N-1:0] prev_i,
  input  logic [N-1:0] mode_i,
  input  logic [N-1:0] sns_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] act_now, act_old, hit, pend_q;

  // sense-adjusted view: active-high / rising after inversion by sense bit
  assign act_now = cur_i ^ sns_i;
  assign act_old = prev_i ^ sns_i;

  for (genvar b = 0; b < N; b++) begin : g_src
    always_comb begin
      if (mode_i[b]) hit[b] = act_now[b] & ~act_old[b];
      else           hit[b] = act_now[b];
    end
  end

  // a fresh detection wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | hit;
  end

  assign pend_o = pend_q;

  // R6: a cleared bit with no new detection is gone in the next cycle
  assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_q & $past(clr_i & ~hit)) == '0);

  // R8: an active level source is pending in the next cycle, cleared or not
  assert_level_relatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_q & $past(act_now & ~mode_i)) == $past(act_now & ~mode_i));

  // R9: a pending bit only falls when it was written as 1 to the clear register
  assert_pending_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(pend_q) & ~$past(clr_i) & ~pend_q) == '0);
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [N-1:0]      raw_i,
  input  logic [N-1:0]      pend_i,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      mode_o,
  output logic [N-1:0]      sns_o,
  output logic [N-1:0]      clr_o,
  output logic [N-1:0]      stat_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [N-1:0]      en_q, mode_q, sns_q;
  logic [WORD_W-1:0] rdata_q, rd_mux;
  logic              rvalid_q, in_win, wr_hit;
  reg_idx_e          idx;

  function automatic logic [WORD_W-1:0] widen(input logic [N-1:0] v);
    logic [WORD_W-1:0] r;
    r = '0;
    r[N-1:0] = v;
    return r;
  endfunction

  assign idx    = reg_idx_e'(addr_i[4:2]);
  assign in_win = (addr_i[ADDR_W-1:5] == '0) && (addr_i[1:0] == 2'b00) &&
                  (int'(addr_i[4:2]) <= REG_LAST);
  assign wr_hit = sel_i && wr_i && in_win;

  assign stat_o = pend_i & en_q;
  assign clr_o  = (wr_hit && idx == REG_CLR) ? wdata_i[N-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    if (in_win) begin
      case (idx)
        REG_RAW:  rd_mux = widen(raw_i);
        REG_EN:   rd_mux = widen(en_q);
        REG_MODE: rd_mux = widen(mode_q);
        REG_SNS:  rd_mux = widen(sns_q);
        REG_STAT: rd_mux = widen(stat_o);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      mode_q   <= '0;
      sns_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= sel_i && !wr_i;
      if (sel_i && !wr_i) rdata_q <= rd_mux;
      if (wr_hit) begin
        case (idx)
          REG_EN:   en_q   <= wdata_i[N-1:0];
          REG_MODE: mode_q <= wdata_i[N-1:0];
          REG_SNS:  sns_q  <= wdata_i[N-1:0];
          default:  ;
        endcase
      end
    end
  end

  assign en_o     = en_q;
  assign mode_o   = mode_q;
  assign sns_o    = sns_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R12: read data is returned only in the cycle after a read strobe
  assert_rvalid_after_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_q |-> $past(sel_i && !wr_i));
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      src_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              irq_o
);
  logic [N-1:0] cur, prev, pend, en, mode, sns, clr, stat;
  logic         irq_q;

  intc_sync #(.N(N), .STAGES(2)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_i(src_i), .cur_o(cur), .prev_o(prev)
  );

  intc_detect #(.N(N)) i_detect (
    .clk(clk), .rst_n(rst_n), .cur_i(cur), .prev_i(prev),
    .mode_i(mode), .sns_i(sns), .clr_i(clr), .pend_o(pend)
  );

  intc_regs #(.N(N)) i_regs (
    .clk(clk), .rst_n(rst_n), .sel_i(bus_sel_i), .wr_i(bus_wr_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .raw_i(cur), .pend_i(pend),
    .en_o(en), .mode_o(mode), .sns_o(sns), .clr_o(clr), .stat_o(stat),
    .rdata_o(bus_rdata_o), .rvalid_o(bus_rvalid_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |stat;
  end

  assign irq_o = irq_q;

  // R10: the request follows pending-and-enabled with one clock of delay
  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_q == |($past(pend) & $past(en)));

  // R7: no request is raised while nothing enabled was pending
  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & en) == '0) |=> !irq_q);
endmodule

// File: tb/test_intc_top.sv
`timescale 1ns/1ps
module test_intc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, irq;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [11:0] A_RAW = 12'h000, A_EN = 12'h004, A_CLR = 12'h008,
                          A_MODE = 12'h00C, A_SNS = 12'h010, A_STAT = 12'h014;

  always #2.5 clk = ~clk;

  intc_top i_intc_top (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_rvalid_o(rvalid), .irq_o(irq)
  );

  // monitor: pops one expectation per returned read
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read data: actual %h expected none", rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic expect_read(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic check_irq(input logic e, input string t);
    tests++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R1: reset state
    expect_read(A_EN,   32'h0, "R1 enable");
    expect_read(A_MODE, 32'h0, "R1 mode");
    expect_read(A_SNS,  32'h0, "R1 sense");
    expect_read(A_STAT, 32'h0, "R1 status");
    check_irq(1'b0, "R1 irq");

    // R2: level-high source 0
    bus_write(A_EN, 32'h1);
    src[0] = 1'b1; idle(5);
    expect_read(A_STAT, 32'h1, "R2 level high pending");
    check_irq(1'b1, "R2 irq");
    src[0] = 1'b0; idle(5);
    expect_read(A_STAT, 32'h1, "R2 held after input low");
    bus_write(A_CLR, 32'h1); idle(3);
    expect_read(A_STAT, 32'h0, "R2 cleared");
    check_irq(1'b0, "R2 irq low");

    // R12: configuration: bit1 level-low, bit2 rising, bit3 falling
    src[1] = 1'b1; src[3] = 1'b1; idle(4);
    bus_write(A_MODE, 32'h0000_000C);
    bus_write(A_SNS,  32'h0000_000A);
    idle(5);
    bus_write(A_CLR, 32'hFFFF_FFFF);
    bus_write(A_EN,  32'h0000_000E);
    expect_read(A_MODE, 32'h0000_000C, "R12 mode readback");
    expect_read(A_SNS,  32'h0000_000A, "R12 sense readback");
    expect_read(A_EN,   32'h0000_000E, "R12 enable readback");
    expect_read(A_CLR,  32'h0, "R12 clear reads zero");
    expect_read(A_STAT, 32'h0, "R7 idle status");
    idle(2);
    check_irq(1'b0, "R7 idle irq");

    // R3: active-low
    src[1] = 1'b0; idle(5);
    expect_read(A_STAT, 32'h2, "R3 level low pending");
    // R8: clear while still active
    bus_write(A_CLR, 32'h2);
    expect_read(A_STAT, 32'h2, "R8 relatched immediately");
    idle(2);
    check_irq(1'b1, "R8 irq stays high");
    src[1] = 1'b1; idle(5);
    bus_write(A_CLR, 32'h2); idle(3);
    expect_read(A_STAT, 32'h0, "R3 cleared when inactive");

    // R4: rising edge
    src[2] = 1'b1; idle(5);
    expect_read(A_STAT, 32'h4, "R4 rising latched");
    src[2] = 1'b0; idle(5);
    expect_read(A_STAT, 32'h4, "R4 held after fall");
    // R5: falling edge
    src[3] = 1'b0; idle(5);
    expect_read(A_STAT, 32'hC, "R5 falling latched");
    // R6: selective clear
    bus_write(A_CLR, 32'h4); idle(1);
    expect_read(A_STAT, 32'h8, "R6 only written bit cleared");
    bus_write(A_CLR, 32'h8); idle(1);
    src[3] = 1'b1; idle(5);
    expect_read(A_STAT, 32'h0, "R5 rising ignored on falling source");

    // R9 / R7: disabled edge kept
    bus_write(A_EN, 32'h0000_000A);
    src[2] = 1'b1; idle(4);
    src[2] = 1'b0; idle(5);
    expect_read(A_STAT, 32'h0, "R7 disabled source masked");
    idle(1);
    check_irq(1'b0, "R7 irq masked");
    // R10: exact timing of irq after unmask write
    sel = 1'b1; wr = 1'b1; addr = A_EN; wdata = 32'h0000_000E;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    check_irq(1'b0, "R10 irq not yet");
    expect_read(A_STAT, 32'h4, "R9 edge kept across disable");
    check_irq(1'b1, "R10 irq one clock later");
    bus_write(A_CLR, 32'h4); idle(3);
    check_irq(1'b0, "R10 irq drops after clear");

    // R11: synchroniser latency on raw register
    src[16] = 1'b1;
    expect_read(A_RAW, src & ~32'h0001_0000, "R11 raw edge k");
    expect_read(A_RAW, src & ~32'h0001_0000, "R11 raw edge k+1");
    expect_read(A_RAW, src, "R11 raw edge k+2");

    idle(4);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL missing read data: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule